// File: doc/BRIEF.md
# Daisy-Chained Input Serializer Readout Controller

This block is a serial-bus master that collects the state of a chain of identical input-serializer devices in one chip-select frame. Every device in the chain holds eight digital inputs. When a frame is started, the block pulls chip select low and drives a divided serial clock, using clock polarity 0 and phase 0. It shifts in one byte per device in fast mode, or two bytes per device in status mode, and stores them in a receive buffer.

After the frame the block presents each device's input byte and raw status byte in parallel to a downstream checker, and it pulses a done strobe. The checker returns one fault flag per device. An indexed port reads a single input by its global number. That port returns an error flag in place of the data bit when the device that owns the input is flagged.

Top module: `serchain_reader`

## Requirements
- R1: After reset, cs_n is high, sclk is low, busy and done are low, and every in_bytes and stat_bytes bit is 0.
- R2: A frame carries exactly 16×NDEV sclk rising edges when status_mode is 1 (status mode), and 8×NDEV when status_mode is 0 (fast mode).
- R3: sclk is low whenever cs_n is high. Each sclk half period lasts clk_div+1 clock cycles, so cs_n stays low for exactly 2×(bits in frame)×(clk_div+1) cycles.
- R4: Bits are sampled on rising sclk edges, MSB first. The first byte on the wire is receive byte 0.
- R5: In status mode, device k's input byte is receive byte 2k and its status byte is receive byte 2k+1. In fast mode, device k's input byte is receive byte k and its stat_bytes field is 0. Device k occupies bits [8k+7:8k] of both buses.
- R6: status_mode is captured when a frame starts. Changing it during a frame does not change that frame's length or its byte mapping.
- R7: A start pulse that arrives while busy is high has no effect: the frame length and the single done pulse stay unchanged.
- R8: done is high for exactly one cycle. It is asserted on the same edge that returns cs_n high, and all bytes of the frame are visible on the output buses in that cycle.
- R9: One cycle after sel_idx is applied, sel_bit holds bit sel_idx mod 8 of the input byte of device sel_idx/8.
- R10: When dev_fault of the addressed device is 1, sel_err is 1 and sel_bit is 0 one cycle later; otherwise sel_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a frame when the block is idle |
| status_mode | input | 1 | 1 = two bytes per device, 0 = one byte per device |
| clk_div | input | DIV_W | Serial clock half period, minus one, in clock cycles |
| miso | input | 1 | Serial data from the end of the chain |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select for the whole chain |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| in_bytes | output | 8×NDEV | Input byte of each device |
| stat_bytes | output | 8×NDEV | Raw status byte of each device (0 in fast mode) |
| dev_fault | input | NDEV | Per-device fault flags from the checker |
| sel_idx | input | DEV_W+3 | Global input index for the single read |
| sel_bit | output | 1 | Addressed input value |
| sel_err | output | 1 | Addressed device is flagged as faulting |

## Verification
The hardest situation to reach from the ports is a frame disturbed in flight: a second start pulse and a flip of status_mode both arrive while bits are still shifting. The bench raises both a few half periods into selected frames. It then checks the sclk edge count, the cs_n low time and the byte mapping against the mode that was latched. A slave model in the bench shifts a random byte pattern out on falling sclk edges, so that misplaced or reordered bytes show up as value mismatches.

// File: rtl/serchain_pkg.sv
package serchain_pkg;
  typedef enum logic {ST_IDLE, ST_SHIFT} seq_state_t;
endpackage

// File: rtl/serchain_tick.sv
module serchain_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/serchain_shift.sv
module serchain_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       sample,
  input  logic       din,
  output logic [7:0] byte_val,
  output logic       byte_rdy
);
  logic [6:0] part;
  logic [2:0] nbit;

  assign byte_val = {part, din};
  assign byte_rdy = sample && (nbit == 3'd7);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      part <= '0;
      nbit <= '0;
    end else if (sample) begin
      part <= {part[5:0], din};
      nbit <= nbit + 1'b1;
    end
  end
endmodule

// File: rtl/serchain_store.sv
module serchain_store #(
  parameter int NBYTES = 8,
  localparam int AW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [7:0]        wdata,
  output logic [NBYTES*8-1:0] flat
);
  logic [7:0] mem [NBYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NBYTES; j++) mem[j] <= '0;
    end else if (wr) begin
      mem[addr] <= wdata;
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_flat
    assign flat[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/serchain_reader.sv
module serchain_reader #(
  parameter int NDEV  = 4,
  parameter int DIV_W = 8,
  localparam int NBYTES = 2 * NDEV,
  localparam int AW     = $clog2(NBYTES),
  localparam int BI_W   = $clog2(NBYTES + 1),
  localparam int DEV_W  = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int IDX_W  = DEV_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              status_mode,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              miso,
  output logic              sclk,
  output logic              cs_n,
  output logic              busy,
  output logic              done,
  output logic [NDEV*8-1:0] in_bytes,
  output logic [NDEV*8-1:0] stat_bytes,
  input  logic [NDEV-1:0]   dev_fault,
  input  logic [IDX_W-1:0]  sel_idx,
  output logic              sel_bit,
  output logic              sel_err
);
  import serchain_pkg::*;

  seq_state_t        state;
  logic              mode_q;
  logic [BI_W-1:0]   byte_idx;
  logic [BI_W-1:0]   frame_len;
  logic              tick, sample, byte_rdy;
  logic [7:0]        byte_val;
  logic [NBYTES*8-1:0] raw;

  assign busy      = (state == ST_SHIFT);
  assign frame_len = mode_q ? BI_W'(NBYTES) : BI_W'(NDEV);
  assign sample    = busy && tick && !sclk;

  serchain_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .en(busy), .div(clk_div), .tick(tick)
  );

  serchain_shift u_shift (
    .clk(clk), .rst(rst), .clr(start && !busy), .sample(sample),
    .din(miso), .byte_val(byte_val), .byte_rdy(byte_rdy)
  );

  serchain_store #(.NBYTES(NBYTES)) u_store (
    .clk(clk), .rst(rst), .wr(byte_rdy), .addr(byte_idx[AW-1:0]),
    .wdata(byte_val), .flat(raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      done     <= 1'b0;
      mode_q   <= 1'b0;
      byte_idx <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_SHIFT;
          cs_n     <= 1'b0;
          sclk     <= 1'b0;
          mode_q   <= status_mode;
          byte_idx <= '0;
        end
        default: begin
          if (byte_rdy) byte_idx <= byte_idx + 1'b1;
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (byte_idx == frame_len) begin
                state <= ST_IDLE;
                cs_n  <= 1'b1;
                done  <= 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  for (genvar k = 0; k < NDEV; k++) begin : g_map
    assign in_bytes[k*8 +: 8]   = mode_q ? raw[(2*k)*8 +: 8] : raw[k*8 +: 8];
    assign stat_bytes[k*8 +: 8] = mode_q ? raw[(2*k+1)*8 +: 8] : 8'h00;
  end

  logic [DEV_W-1:0] sel_dev;
  logic [2:0]       sel_pos;
  logic             hit_fault, hit_data, dev_ok;

  assign sel_dev = sel_idx[IDX_W-1:3];
  assign sel_pos = sel_idx[2:0];

  always_comb begin
    hit_fault = 1'b0;
    hit_data  = 1'b0;
    dev_ok    = 1'b0;
    for (int k = 0; k < NDEV; k++) begin
      if (sel_dev == DEV_W'(k)) begin
        dev_ok    = 1'b1;
        hit_fault = dev_fault[k];
        hit_data  = in_bytes[k*8 + int'(sel_pos)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_bit <= 1'b0;
      sel_err <= 1'b0;
    end else begin
      sel_err <= hit_fault || !dev_ok;
      sel_bit <= (hit_fault || !dev_ok) ? 1'b0 : hit_data;
    end
  end
endmodule

// File: rtl/serchain_chk.sv
module serchain_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic sclk,
  input logic cs_n,
  input logic busy,
  input logic done,
  input logic sel_bit,
  input logic sel_err
);
  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_with_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> done);

  // R7
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

  // R10
  err_masks_bit_chk: assert property (@(posedge clk) disable iff (rst)
    sel_err |-> !sel_bit);
endmodule

bind serchain_reader serchain_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .sclk(sclk), .cs_n(cs_n),
  .busy(busy), .done(done), .sel_bit(sel_bit), .sel_err(sel_err)
);

// File: tb/test_serchain_reader.sv
`timescale 1ns/1ps
module test_serchain_reader;
  localparam int NDEV  = 4;
  localparam int DIV_W = 8;
  localparam int IDX_W = 5;

  logic clk = 0, rst = 1, start = 0, status_mode = 0, miso;
  logic [DIV_W-1:0] clk_div = '0;
  logic sclk, cs_n, busy, done, sel_bit, sel_err;
  logic [NDEV*8-1:0] in_bytes, stat_bytes;
  logic [NDEV-1:0] dev_fault = '0;
  logic [IDX_W-1:0] sel_idx = '0;

  int errors = 0, checks = 0;
  int rcnt = 0, lowcnt = 0, dcnt = 0, bitp = 0;
  logic [7:0] fb [2*NDEV];
  logic [7:0] exp_in [NDEV];

  always #2 clk = ~clk;

  serchain_reader #(.NDEV(NDEV), .DIV_W(DIV_W)) i_serchain_reader (
    .clk(clk), .rst(rst), .start(start), .status_mode(status_mode),
    .clk_div(clk_div), .miso(miso), .sclk(sclk), .cs_n(cs_n), .busy(busy),
    .done(done), .in_bytes(in_bytes), .stat_bytes(stat_bytes),
    .dev_fault(dev_fault), .sel_idx(sel_idx), .sel_bit(sel_bit), .sel_err(sel_err)
  );

  // slave chain model: next bit after each falling sclk edge
  always @(negedge cs_n) bitp = 0;
  always @(negedge sclk) if (!cs_n) bitp = bitp + 1;
  assign miso = (bitp < 16*NDEV) ? fb[bitp/8][7-(bitp%8)] : 1'b0;

  always @(posedge sclk) rcnt = rcnt + 1;
  always @(posedge clk) begin
    if (!cs_n) lowcnt = lowcnt + 1;
    if (done) dcnt = dcnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input bit mode, input int div, input bit disturb);
    int wl = mode ? 2 : 1;
    int t = 0;
    for (int j = 0; j < 2*NDEV; j++) fb[j] = 8'($urandom);
    @(negedge clk);
    status_mode = mode; clk_div = DIV_W'(div);
    rcnt = 0; lowcnt = 0; dcnt = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      repeat (5*(div+1)) @(negedge clk);
      start = 1; status_mode = !mode;
      @(negedge clk);
      start = 0;
    end
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R8", "done seen", done, 1);
    chk(cs_n == 1'b1 && busy == 1'b0, "R8", "cs_n/busy at done", {cs_n, busy}, 2'b10);
    chk(rcnt == 8*NDEV*wl, "R2", "sclk rising edges", rcnt, 8*NDEV*wl);
    chk(lowcnt == 2*8*NDEV*wl*(div+1), "R3", "cs_n low cycles", lowcnt, 2*8*NDEV*wl*(div+1));
    for (int k = 0; k < NDEV; k++) begin
      logic [7:0] ei = mode ? fb[2*k] : fb[k];
      logic [7:0] es = mode ? fb[2*k+1] : 8'h00;
      exp_in[k] = ei;
      chk(in_bytes[k*8 +: 8] == ei, disturb ? "R6" : "R5", "input byte", in_bytes[k*8 +: 8], ei);
      chk(stat_bytes[k*8 +: 8] == es, "R4", "status byte", stat_bytes[k*8 +: 8], es);
    end
    @(negedge clk);
    chk(dcnt == 1 && done == 1'b0, disturb ? "R7" : "R8", "done pulse count", dcnt, 1);
    status_mode = mode;
  endtask

  task automatic sel_one(input int idx);
    bit e;
    bit b;
    sel_idx = IDX_W'(idx);
    @(negedge clk);
    e = dev_fault[idx/8];
    b = e ? 1'b0 : exp_in[idx/8][idx%8];
    chk(sel_err == e, "R10", "sel_err", sel_err, e);
    chk(sel_bit == b, "R9", "sel_bit", sel_bit, b);
  endtask

  task automatic sel_sweep();
    @(negedge clk);
    dev_fault = '0;
    sel_one(0);
    sel_one(8*NDEV-1);
    dev_fault = NDEV'($urandom);
    for (int n = 0; n < 10; n++) sel_one(int'($urandom % (8*NDEV)));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int j = 0; j < 2*NDEV; j++) fb[j] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && busy == 0 && done == 0, "R1", "idle pins",
        {cs_n, sclk, busy, done}, 4'b1000);
    chk(in_bytes == '0 && stat_bytes == '0, "R1", "buffers clear",
        {in_bytes, stat_bytes}, 0);
    run_frame(1, 0, 0); sel_sweep();
    run_frame(0, 1, 0); sel_sweep();
    run_frame(1, 2, 1); sel_sweep();
    run_frame(0, 0, 1);
    for (int n = 0; n < 4; n++) begin
      run_frame(bit'($urandom % 2), int'($urandom % 4), bit'($urandom % 2));
      sel_sweep();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule